// File: doc/BRIEF.md
# Shared Bidirectional Interrupt Line Controller

This block owns a single active-low, wired interrupt line that is shared by an embedded core and a remote host. A direction bit written by the core decides which way the line works. With the bit clear, the line is an input and carries a level-sensitive request into the core. With the bit set, the core drives the line to interrupt the host. A single control bit serves both modes. In input mode it enables or masks the incoming request. In output mode it sets the driven level. The host acknowledges a request by writing a one, and that write toggles the same control bit.

Every update that is visible on the pad or in the status mirror is aligned to an instruction-phase strobe that marks the first T-state of each instruction. The block also watches a separate non-maskable request input. It latches a falling edge on that input as a pending request, and it clears that request when the core signals recognition. Both external inputs pass through two-flop synchronizers before any detection.

Top module: `shared_irq_ctrl`

## Requirements
- R1: After reset the direction bit, control bit and lock bit read 0, `pad_oe_o` is 0, `pad_out_o` is 1, `line_mirror_o` is 1, and neither pending output is set.
- R2: With the direction bit at 0, `irq_pend_o` equals (synchronized line is low) AND (control bit is 1), two clock edges after the pad input changes. With the direction bit at 1, `irq_pend_o` is 0.
- R3: The incoming request is a level. It drops when the line returns high, even without recognition. It stays asserted through `irq_recog_i` while the line stays low.
- R4: `line_mirror_o` captures the synchronized line level only on an edge where `instr_t1_i` is 1, in both modes, and holds its value otherwise.
- R5: With the direction bit at 1, `pad_oe_o` is 1. `pad_out_o` takes the control bit's value only on an edge where `instr_t1_i` is 1, so a core write reaches the pin at the next instruction start.
- R6: In output mode, a host acknowledge write with data 1 inverts the control bit on the second clock edge after the edge that samples the write. A write with data 0 has no effect. In input mode the write has no effect.
- R7: `host_ack_rd_o` always reads the current control bit.
- R8: If a core write to the control bit and a host toggle land on the same edge, the control bit takes the core-written value.
- R9: While the lock bit is 1 on the edge that samples a host acknowledge write, that write is discarded.
- R10: A falling edge on `nmi_i` sets `nmi_pend_o` on the third clock edge after the input falls. `irq_recog_i` does not clear it. `nmi_recog_i` clears it unless a new falling edge arrives on the same edge, in which case the new edge wins. A low level that is held does not set it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pad_line_i | input | 1 | Sensed level of the shared interrupt line |
| pad_oe_o | output | 1 | Pad output enable (1 = block drives the line) |
| pad_out_o | output | 1 | Level driven onto the line when enabled |
| instr_t1_i | input | 1 | Strobe marking the first T-state of an instruction |
| core_dir_we_i | input | 1 | Core write enable for the direction bit |
| core_dir_i | input | 1 | Direction value (0 input, 1 output) |
| core_mask_we_i | input | 1 | Core write enable for the control bit |
| core_mask_i | input | 1 | Control bit value (enable in input mode, level in output mode) |
| core_lock_we_i | input | 1 | Core write enable for the host lock bit |
| core_lock_i | input | 1 | Lock value (1 blocks host acknowledge writes) |
| core_dir_o | output | 1 | Direction bit readback |
| core_mask_o | output | 1 | Control bit readback |
| core_lock_o | output | 1 | Lock bit readback |
| line_mirror_o | output | 1 | Line level sampled at instruction start |
| host_ack_we_i | input | 1 | Host acknowledge write strobe |
| host_ack_wdata_i | input | 1 | Host acknowledge write data (1 toggles) |
| host_ack_rd_o | output | 1 | Host view of the control bit |
| nmi_i | input | 1 | Non-maskable request input, falling-edge active |
| irq_pend_o | output | 1 | Level request pending to the core |
| irq_recog_i | input | 1 | Core has recognized the level request |
| nmi_pend_o | output | 1 | Non-maskable request pending to the core |
| nmi_recog_i | input | 1 | Core has recognized the non-maskable request |

## Verification
Each result arrives after a fixed number of edges. The level request follows a pad change after two edges, once the synchronizer has filled. The non-maskable pending flag appears after three edges. A host toggle lands on the second edge after the edge that samples the write. Pin and mirror updates land on the next edge at which the strobe is high. The bench drives inputs one time unit after a rising edge and samples at the same point after a counted number of edges. For every delayed result it checks the edges before the due edge as well as the due edge, so that a result arriving one edge early or late is caught. The collision case is timed so that the core write lands exactly on the toggle's due edge.

// File: rtl/shared_irq_pkg.sv
package shared_irq_pkg;

    localparam int unsigned SYNC_STAGES = 2;
    localparam int unsigned ACK_DELAY   = 2;

    typedef struct packed {
        logic dir;     // 0 line is input, 1 line is driven
        logic mask;    // enable (input mode) or drive level (output mode)
        logic lock;    // host acknowledge lock-out
        logic drv;     // level presented on the pad
        logic mirror;  // line level captured at instruction start
    } ctl_state_t;

    localparam ctl_state_t CTL_RESET = '{
        dir:    1'b0,
        mask:   1'b0,
        lock:   1'b0,
        drv:    1'b1,
        mirror: 1'b1
    };

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RESET_VAL}};
        else         chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/ack_delay_pipe.sv
module ack_delay_pipe #(
    parameter int unsigned DELAY = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    output logic fire_o
);
    logic [DELAY-1:0] stage_d, stage_q;

    generate
        if (DELAY == 1) begin : g_single
            always_comb stage_d = req_i;
        end else begin : g_chain
            always_comb stage_d = {stage_q[DELAY-2:0], req_i};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= stage_d;
    end

    assign fire_o = stage_q[DELAY-1];
endmodule

// File: rtl/nmi_edge_det.sv
module nmi_edge_det (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_i,
    input  logic recog_i,
    output logic fall_o,
    output logic pend_o
);
    typedef struct packed {
        logic prev;
        logic pend;
    } nmi_state_t;

    nmi_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        fall_o    = st_q.prev & ~level_i;
        st_d.prev = level_i;
        if (recog_i) st_d.pend = 1'b0;
        if (fall_o)  st_d.pend = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{prev: 1'b1, pend: 1'b0};
        else         st_q <= st_d;
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/shared_irq_ctrl.sv
module shared_irq_ctrl
    import shared_irq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pad_line_i,
    output logic pad_oe_o,
    output logic pad_out_o,
    input  logic instr_t1_i,
    input  logic core_dir_we_i,
    input  logic core_dir_i,
    input  logic core_mask_we_i,
    input  logic core_mask_i,
    input  logic core_lock_we_i,
    input  logic core_lock_i,
    output logic core_dir_o,
    output logic core_mask_o,
    output logic core_lock_o,
    output logic line_mirror_o,
    input  logic host_ack_we_i,
    input  logic host_ack_wdata_i,
    output logic host_ack_rd_o,
    input  logic nmi_i,
    output logic irq_pend_o,
    input  logic irq_recog_i,
    output logic nmi_pend_o,
    input  logic nmi_recog_i
);
    ctl_state_t ctl_d, ctl_q;
    logic       line_s;
    logic       nmi_s;
    logic       ack_req;
    logic       ack_fire;
    logic       nmi_fall;

    irq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_line_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(pad_line_i),
        .sync_o (line_s)
    );

    irq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_nmi_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(nmi_i),
        .sync_o (nmi_s)
    );

    // Lock is judged on the edge that samples the host write.
    assign ack_req = host_ack_we_i & host_ack_wdata_i & ~ctl_q.lock;

    ack_delay_pipe #(.DELAY(ACK_DELAY)) u_ack_pipe (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .req_i (ack_req),
        .fire_o(ack_fire)
    );

    nmi_edge_det u_nmi (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .level_i(nmi_s),
        .recog_i(nmi_recog_i),
        .fall_o (nmi_fall),
        .pend_o (nmi_pend_o)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (core_dir_we_i)  ctl_d.dir  = core_dir_i;
        if (core_lock_we_i) ctl_d.lock = core_lock_i;
        // host toggle first, a coincident core write overrides it
        if (ack_fire && ctl_q.dir) ctl_d.mask = ~ctl_q.mask;
        if (core_mask_we_i)        ctl_d.mask = core_mask_i;
        if (instr_t1_i) begin
            ctl_d.mirror = line_s;
            if (ctl_q.dir) ctl_d.drv = ctl_q.mask;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctl_q <= CTL_RESET;
        else         ctl_q <= ctl_d;
    end

    assign pad_oe_o      = ctl_q.dir;
    assign pad_out_o     = ctl_q.drv;
    assign core_dir_o    = ctl_q.dir;
    assign core_mask_o   = ctl_q.mask;
    assign core_lock_o   = ctl_q.lock;
    assign host_ack_rd_o = ctl_q.mask;
    assign line_mirror_o = ctl_q.mirror;
    assign irq_pend_o    = ~ctl_q.dir & ~line_s & ctl_q.mask;
endmodule

// File: rtl/shared_irq_ctrl_checker.sv
module shared_irq_ctrl_checker (
    input logic clk_i,
    input logic rst_ni,
    input logic instr_t1_i,
    input logic core_dir_o,
    input logic core_mask_o,
    input logic core_mask_we_i,
    input logic pad_out_o,
    input logic line_mirror_o,
    input logic irq_pend_o,
    input logic nmi_recog_i,
    input logic nmi_fall,
    input logic nmi_pend_o
);
    assert_pin_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !instr_t1_i |=> $stable(pad_out_o));

    assert_mirror_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !instr_t1_i |=> $stable(line_mirror_o));

    assert_masked_no_pend_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !core_mask_o |-> !irq_pend_o);

    assert_output_no_pend_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_dir_o |-> !irq_pend_o);

    assert_input_mode_no_toggle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!core_dir_o && !core_mask_we_i) |=> $stable(core_mask_o));

    assert_nmi_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (nmi_recog_i && !nmi_fall) |=> !nmi_pend_o);
endmodule

bind shared_irq_ctrl shared_irq_ctrl_checker u_checker (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .instr_t1_i    (instr_t1_i),
    .core_dir_o    (core_dir_o),
    .core_mask_o   (core_mask_o),
    .core_mask_we_i(core_mask_we_i),
    .pad_out_o     (pad_out_o),
    .line_mirror_o (line_mirror_o),
    .irq_pend_o    (irq_pend_o),
    .nmi_recog_i   (nmi_recog_i),
    .nmi_fall      (nmi_fall),
    .nmi_pend_o    (nmi_pend_o)
);

// File: tb/shared_irq_ctrl_bench.sv
`timescale 1ns/1ps
module shared_irq_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_line = 1'b1;
    logic pad_line, pad_oe, pad_out;
    logic t1 = 0, dir_we = 0, dir_v = 0, mask_we = 0, mask_v = 0, lock_we = 0, lock_v = 0;
    logic dir_o, mask_o, lock_o, mirror_o, ack_rd;
    logic ack_we = 0, ack_d = 0, nmi = 1, irq_recog = 0, nmi_recog = 0;
    logic irq_pend, nmi_pend;
    int   n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    assign pad_line = pad_oe ? pad_out : ext_line;

    shared_irq_ctrl u_shared_irq_ctrl (
        .clk_i(clk), .rst_ni(rst_n),
        .pad_line_i(pad_line), .pad_oe_o(pad_oe), .pad_out_o(pad_out),
        .instr_t1_i(t1),
        .core_dir_we_i(dir_we), .core_dir_i(dir_v),
        .core_mask_we_i(mask_we), .core_mask_i(mask_v),
        .core_lock_we_i(lock_we), .core_lock_i(lock_v),
        .core_dir_o(dir_o), .core_mask_o(mask_o), .core_lock_o(lock_o),
        .line_mirror_o(mirror_o),
        .host_ack_we_i(ack_we), .host_ack_wdata_i(ack_d), .host_ack_rd_o(ack_rd),
        .nmi_i(nmi), .irq_pend_o(irq_pend), .irq_recog_i(irq_recog),
        .nmi_pend_o(nmi_pend), .nmi_recog_i(nmi_recog)
    );

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic core_mask(logic v);
        mask_we = 1; mask_v = v; tick(); mask_we = 0;
    endtask

    task automatic host_ack(logic d);
        ack_we = 1; ack_d = d; tick(); ack_we = 0;
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick();
        // R1 reset state
        check("R1 dir", dir_o, 0);
        check("R1 mask", mask_o, 0);
        check("R1 lock", lock_o, 0);
        check("R1 oe", pad_oe, 0);
        check("R1 out", pad_out, 1);
        check("R1 mirror", mirror_o, 1);
        check("R1 irq", irq_pend, 0);
        check("R1 nmi", nmi_pend, 0);

        // R2 sweep of mask x line in input mode
        for (int m = 0; m < 2; m++) begin
            for (int l = 0; l < 2; l++) begin
                core_mask(m[0]);
                ext_line = l[0];
                tick(2);
                check("R2 level", irq_pend, (!l[0]) && m[0]);
                check("R7 readback", ack_rd, m[0]);
            end
        end
        ext_line = 1; tick(2);

        // R3 level, held through recognition, lost when line rises
        core_mask(1);
        ext_line = 0;
        tick();
        check("R3 sync not yet", irq_pend, 0);
        tick();
        check("R3 raised", irq_pend, 1);
        irq_recog = 1; tick(); irq_recog = 0;
        check("R3 held after recog", irq_pend, 1);
        ext_line = 1; tick(2);
        check("R3 dropped", irq_pend, 0);

        // R4 mirror only at strobe
        ext_line = 0; tick(3);
        check("R4 no strobe", mirror_o, 1);
        t1 = 1; tick(); t1 = 0;
        check("R4 strobe", mirror_o, 0);
        ext_line = 1; tick(3);
        check("R4 hold", mirror_o, 0);
        t1 = 1; tick(); t1 = 0;
        check("R4 strobe2", mirror_o, 1);

        // R6 input mode: host write ignored
        host_ack(1); tick(3);
        check("R6 input ignored", mask_o, 1);

        // R5 output mode
        dir_we = 1; dir_v = 1; tick(); dir_we = 0;
        check("R5 oe", pad_oe, 1);
        check("R2 out mode", irq_pend, 0);
        core_mask(0);
        tick();
        check("R5 no strobe", pad_out, 1);
        t1 = 1; tick(); t1 = 0;
        check("R5 strobe", pad_out, 0);
        tick(2);
        t1 = 1; tick(); t1 = 0;
        check("R4 out mirror", mirror_o, 0);
        // core write on same edge as strobe: pin keeps old value
        mask_we = 1; mask_v = 1; t1 = 1; tick(); mask_we = 0; t1 = 0;
        check("R5 same edge old", pad_out, 0);
        t1 = 1; tick(); t1 = 0;
        check("R5 next instr", pad_out, 1);

        // R6 toggle timing sweep
        for (int s = 0; s < 2; s++) begin
            core_mask(s[0]);
            host_ack(1);
            check("R6 edge0", mask_o, s[0]);
            tick();
            check("R6 edge1", mask_o, s[0]);
            tick();
            check("R6 edge2", mask_o, !s[0]);
            check("R7 readback", ack_rd, !s[0]);
            host_ack(0); tick(3);
            check("R6 zero write", mask_o, !s[0]);
        end

        // R9 lock
        core_mask(0);
        lock_we = 1; lock_v = 1; tick(); lock_we = 0;
        host_ack(1); tick(3);
        check("R9 locked", mask_o, 0);
        lock_we = 1; lock_v = 0; tick(); lock_we = 0;
        host_ack(1); tick(2);
        check("R9 unlocked", mask_o, 1);

        // R8 collision
        for (int v = 0; v < 2; v++) begin
            core_mask(1);
            host_ack(1);
            tick();
            mask_we = 1; mask_v = v[0]; tick(); mask_we = 0;
            check("R8 core wins", mask_o, v[0]);
        end

        // R10 nmi edge
        nmi = 0;
        tick(2);
        check("R10 not yet", nmi_pend, 0);
        tick();
        check("R10 set", nmi_pend, 1);
        irq_recog = 1; tick(); irq_recog = 0;
        check("R10 irq recog no clear", nmi_pend, 1);
        nmi_recog = 1; tick(); nmi_recog = 0;
        check("R10 cleared", nmi_pend, 0);
        tick(4);
        check("R10 held low no reset", nmi_pend, 0);
        nmi = 1; tick(4);
        nmi = 0; tick(2);
        nmi_recog = 1; tick(); nmi_recog = 0;
        check("R10 new edge wins", nmi_pend, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule